// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block sits beside the access sequencer of an asynchronous DRAM controller. It owns the power-up bring-up and the periodic refresh. After reset it keeps the memory idle for a configurable pause, then runs a burst of warm-up refresh cycles. Only then does it raise `init_done` and start granting accesses.

In normal operation an interval timer adds one refresh request per refresh slot to a small pending counter. The slot is the refresh window divided by the number of rows, in clock cycles. Pending refreshes are taken whenever the bus is free of access requests. While accesses keep coming, requests are allowed to build up. When the counter reaches its limit, grants stop and a refresh is forced as soon as the current access ends. Refreshes use the CAS-before-RAS form, so the DRAM's internal row counter supplies the row. The scheduler generates RAS, CAS and the write strobe itself and multiplexes them onto the DRAM pins in place of the sequencer's strobes.

Sequencer contract: an access starts in a cycle where `acc_req` and `acc_gnt` are both high. `seq_busy` is high from the next cycle until the access, including its own RAS precharge, is complete.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset and for the first PAUSE_CYC cycles after reset release, all three DRAM strobes are high and `init_done` and `acc_gnt` are low. Sequencer strobes have no effect on the pins in this time.
- R2: After the pause, exactly WARMUP_REFS (8) refresh cycles run back to back. `init_done` rises one cycle after the last of them returns to idle, stays high from then on, and `acc_gnt` is low until it rises.
- R3: In every refresh, CAS falls T_CSR cycles before RAS, stays low for T_CHR cycles after RAS falls, then rises while RAS stays low until RAS has been low for T_RAS cycles.
- R4: The write strobe is high for the whole of every refresh cycle.
- R5: Before CAS falls for a refresh, RAS and CAS have both been high for at least T_CRP cycles. After RAS rises, both stay high for T_RP cycles.
- R6: After `init_done`, one refresh request is added every INTERVAL_CYC cycles. The first is added INTERVAL_CYC cycles after `init_done` rises.
- R7: A pending refresh starts in the first idle cycle with `acc_req` and `seq_busy` low. CAS falls 1+T_CRP cycles after that cycle. Pending refreshes drain back to back, one every T_CRP+T_CSR+T_RAS+T_RP+1 cycles.
- R8: While `acc_req` is held high, requests accumulate. `acc_gnt` is high while fewer than MAX_PEND (8) are pending and no refresh runs. It is low once MAX_PEND are pending, and one refresh is then forced.
- R9: A refresh never starts in a cycle where `seq_busy` is high.
- R10: After `init_done`, and while no refresh runs, the DRAM strobes follow the sequencer strobes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_req | input | 1 | Sequencer wants to start an access |
| seq_busy | input | 1 | Sequencer access in progress |
| seq_ras_n | input | 1 | Sequencer row strobe, active low |
| seq_cas_n | input | 1 | Sequencer column strobe, active low |
| seq_we_n | input | 1 | Sequencer write strobe, active low |
| acc_gnt | output | 1 | Sequencer may start an access this cycle |
| init_done | output | 1 | Warm-up complete; gates sequencer readiness |
| dram_ras_n | output | 1 | Row strobe to the DRAM |
| dram_cas_n | output | 1 | Column strobe to the DRAM |
| dram_we_n | output | 1 | Write strobe to the DRAM |

## Verification
A corrupted pending count shows at the pins within one refresh slot, as a refresh missing from or added to the drain that follows a release of `acc_req`. It also shows as `acc_gnt` falling one request too early or too late. A wrong pause or interval count moves the first CAS fall of a burst by whole cycles, so every refresh start is compared against its exactly predicted cycle. A wrong phase in the cycle generator breaks the strobe shape within the same refresh. That shape is compared cycle by cycle across the whole window, including the precharge.

// File: rtl/drs_pkg.sv
package drs_pkg;
   // Phases of one CAS-before-RAS refresh cycle, in issue order
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PREP,    // strobes high, CAS precharge before the cycle
      ST_CSET,    // CAS low, RAS high: setup before RAS
      ST_BOTH,    // both low: CAS hold after RAS
      ST_RHOLD,   // RAS low only, remainder of the RAS width
      ST_PRECH    // both high: RAS precharge
   } cbr_st_e;
endpackage

// File: rtl/drs_tick_gen.sv
module drs_tick_gen #(
   parameter int unsigned PAUSE_CYC    = 25000,
   parameter int unsigned INTERVAL_CYC = 1953
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic pause_fire,
   output logic tick
);
   localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
   localparam int unsigned IW = $clog2(INTERVAL_CYC);

   logic [PW-1:0] pcnt;
   logic [IW-1:0] icnt;

   // power-up pause: one-shot pulse in the last pause cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pcnt <= PW'(PAUSE_CYC);
      else if (pcnt != '0)   pcnt <= pcnt - 1'b1;
   end
   assign pause_fire = (pcnt == PW'(1));

   // refresh slot timer, frozen until run
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    icnt <= IW'(INTERVAL_CYC - 1);
      else if (run)  icnt <= (icnt == '0) ? IW'(INTERVAL_CYC - 1) : icnt - 1'b1;
   end
   assign tick = run && (icnt == '0);
endmodule

// File: rtl/drs_pend_ctr.sv
module drs_pend_ctr #(
   parameter int unsigned MAX_PEND  = 8,
   parameter int unsigned INIT_LOAD = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic inc,
   input  logic dec,
   output logic pend_any,
   output logic pend_full
);
   localparam int unsigned CW = $clog2(MAX_PEND + 1);

   logic [CW-1:0] cnt;
   logic          inc_eff;

   // a new request is dropped only when full and nothing drains
   assign inc_eff = inc && ((cnt != CW'(MAX_PEND)) || dec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (load)     cnt <= CW'(INIT_LOAD);
      else begin
         case ({inc_eff, dec})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign pend_any  = (cnt != '0);
   assign pend_full = (cnt == CW'(MAX_PEND));
endmodule

// File: rtl/drs_cbr_fsm.sv
module drs_cbr_fsm import drs_pkg::*; #(
   parameter int unsigned T_CRP = 1,
   parameter int unsigned T_CSR = 1,
   parameter int unsigned T_CHR = 2,
   parameter int unsigned T_RAS = 7,
   parameter int unsigned T_RP  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic ras_n,
   output logic cas_n,
   output logic we_n
);
   localparam int unsigned M1   = (T_CRP > T_CSR) ? T_CRP : T_CSR;
   localparam int unsigned M2   = (T_RAS > T_RP)  ? T_RAS : T_RP;
   localparam int unsigned TMAX = (M1 > M2) ? M1 : M2;
   localparam int unsigned DW   = $clog2(TMAX + 1);

   cbr_st_e       st;
   logic [DW-1:0] cnt;

   function automatic cbr_st_e next_of(cbr_st_e s);
      case (s)
         ST_PREP:  return ST_CSET;
         ST_CSET:  return ST_BOTH;
         ST_BOTH:  return ST_RHOLD;
         ST_RHOLD: return ST_PRECH;
         default:  return ST_IDLE;
      endcase
   endfunction

   function automatic logic [DW-1:0] len_of(cbr_st_e s);
      case (s)
         ST_PREP:  return DW'(T_CRP - 1);
         ST_CSET:  return DW'(T_CSR - 1);
         ST_BOTH:  return DW'(T_CHR - 1);
         ST_RHOLD: return DW'(T_RAS - T_CHR - 1);
         ST_PRECH: return DW'(T_RP - 1);
         default:  return '0;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else if (st == ST_IDLE) begin
         if (start) begin
            st  <= ST_PREP;
            cnt <= len_of(ST_PREP);
         end
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end else begin
         st  <= next_of(st);
         cnt <= len_of(next_of(st));
      end
   end

   assign busy  = (st != ST_IDLE);
   assign ras_n = !((st == ST_BOTH) || (st == ST_RHOLD));
   assign cas_n = !((st == ST_CSET) || (st == ST_BOTH));
   assign we_n  = 1'b1;   // write strobe held high: keeps test mode out
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched import drs_pkg::*; #(
   parameter int unsigned CLK_KHZ       = 125000,
   parameter int unsigned PAUSE_US      = 200,
   parameter int unsigned REF_WINDOW_MS = 64,
   parameter int unsigned REF_ROWS      = 4096,
   parameter int unsigned PAUSE_CYC     = CLK_KHZ / 1000 * PAUSE_US,
   parameter int unsigned INTERVAL_CYC  = CLK_KHZ * REF_WINDOW_MS / REF_ROWS,
   parameter int unsigned WARMUP_REFS   = 8,
   parameter int unsigned MAX_PEND      = 8,
   parameter int unsigned T_CRP         = 1,
   parameter int unsigned T_CSR         = 1,
   parameter int unsigned T_CHR         = 2,
   parameter int unsigned T_RAS         = 7,
   parameter int unsigned T_RP          = 4,
   parameter int unsigned T_RC          = 11,
   parameter int unsigned REG_PINS      = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic acc_req,
   input  logic seq_busy,
   input  logic seq_ras_n,
   input  logic seq_cas_n,
   input  logic seq_we_n,
   output logic acc_gnt,
   output logic init_done,
   output logic dram_ras_n,
   output logic dram_cas_n,
   output logic dram_we_n
);
   // elaboration-time parameter checks
   if (PAUSE_CYC < 1)                    begin : g_bad_pause  $error("PAUSE_CYC must be at least 1"); end
   if (INTERVAL_CYC < 2)                 begin : g_bad_ivl    $error("INTERVAL_CYC must be at least 2"); end
   if (WARMUP_REFS < 1 || WARMUP_REFS > MAX_PEND)
                                         begin : g_bad_warm   $error("WARMUP_REFS must be 1..MAX_PEND"); end
   if (T_CRP < 1 || T_CSR < 1 || T_CHR < 1 || T_RP < 1)
                                         begin : g_bad_phase  $error("every refresh phase needs one cycle"); end
   if (T_RAS <= T_CHR)                   begin : g_bad_ras    $error("T_RAS must exceed T_CHR"); end
   if (T_RAS + T_RP < T_RC)              begin : g_bad_rc     $error("T_RAS + T_RP below cycle time"); end
   if (REG_PINS > 1)                     begin : g_bad_reg    $error("REG_PINS is 0 or 1"); end

   logic pause_fire, tick;
   logic pend_any, pend_full;
   logic ref_busy, start, init_phase;
   logic f_ras_n, f_cas_n, f_we_n;
   logic m_ras_n, m_cas_n, m_we_n;
   logic use_seq;

   drs_tick_gen #(
      .PAUSE_CYC   (PAUSE_CYC),
      .INTERVAL_CYC(INTERVAL_CYC)
   ) i_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (init_done),
      .pause_fire(pause_fire),
      .tick      (tick)
   );

   drs_pend_ctr #(
      .MAX_PEND (MAX_PEND),
      .INIT_LOAD(WARMUP_REFS)
   ) i_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pause_fire),
      .inc      (tick),
      .dec      (start),
      .pend_any (pend_any),
      .pend_full(pend_full)
   );

   drs_cbr_fsm #(
      .T_CRP(T_CRP),
      .T_CSR(T_CSR),
      .T_CHR(T_CHR),
      .T_RAS(T_RAS),
      .T_RP (T_RP)
   ) i_cbr (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .busy (ref_busy),
      .ras_n(f_ras_n),
      .cas_n(f_cas_n),
      .we_n (f_we_n)
   );

   // warm-up forces refreshes; later, take them on idle bus or when full
   assign start   = !ref_busy && !seq_busy && pend_any &&
                    (!init_done || pend_full || !acc_req);
   assign acc_gnt = init_done && !ref_busy && !pend_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_phase <= 1'b0;
         init_done  <= 1'b0;
      end else if (pause_fire) begin
         init_phase <= 1'b1;
      end else if (init_phase && !pend_any && !ref_busy) begin
         init_phase <= 1'b0;
         init_done  <= 1'b1;
      end
   end

   // strobe mux shared with the sequencer
   assign use_seq = init_done && !ref_busy;
   assign m_ras_n = use_seq ? seq_ras_n : f_ras_n;
   assign m_cas_n = use_seq ? seq_cas_n : f_cas_n;
   assign m_we_n  = use_seq ? seq_we_n  : f_we_n;

   if (REG_PINS != 0) begin : g_pin_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) {dram_ras_n, dram_cas_n, dram_we_n} <= 3'b111;
         else        {dram_ras_n, dram_cas_n, dram_we_n} <= {m_ras_n, m_cas_n, m_we_n};
      end
   end else begin : g_pin_comb
      assign dram_ras_n = m_ras_n;
      assign dram_cas_n = m_cas_n;
      assign dram_we_n  = m_we_n;
   end
endmodule

// File: rtl/drs_checker.sv
module drs_checker (
   input logic clk,
   input logic rst_n,
   input logic acc_req,
   input logic acc_gnt,
   input logic seq_busy,
   input logic init_done,
   input logic dram_ras_n,
   input logic dram_cas_n,
   input logic dram_we_n,
   input logic ref_busy
);
   AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_ras_n) && ref_busy) |-> $past(!dram_cas_n)) else $error("cas not ahead of ras"); // R3

   AST_WRITE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ref_busy |-> dram_we_n) else $error("write strobe low in refresh"); // R4

   AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dram_ras_n) && ref_busy) |=> (dram_ras_n && dram_cas_n)) else $error("precharge cut short"); // R5

   AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done) else $error("init_done fell"); // R2

   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_busy) |-> $past(!seq_busy)) else $error("refresh over busy access"); // R9

   AST_NO_GRANT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ref_busy) && init_done) |-> $past(!(acc_req && acc_gnt))) else $error("refresh over granted access"); // R8
endmodule

bind dram_refresh_sched drs_checker i_drs_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_req   (acc_req),
   .acc_gnt   (acc_gnt),
   .seq_busy  (seq_busy),
   .init_done (init_done),
   .dram_ras_n(dram_ras_n),
   .dram_cas_n(dram_cas_n),
   .dram_we_n (dram_we_n),
   .ref_busy  (ref_busy)
);

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;
   localparam int P     = 50;
   localparam int I     = 150;
   localparam int TCRP  = 1;
   localparam int TCSR  = 1;
   localparam int TCHR  = 2;
   localparam int TRAS  = 7;
   localparam int TRP   = 4;
   localparam int STEP  = TCRP + TCSR + TRAS + TRP + 1;  // start to start, back to back
   localparam int WIN   = TCSR + TRAS + TRP;             // CAS fall to end of precharge
   localparam int FO    = 1 + TCRP;                      // start cycle to CAS fall
   localparam int D     = P + 8 * STEP + 1;              // init_done rises
   localparam int TFULL = D + 11 * I;                    // eighth pending request lands

   typedef struct { int t; string req; } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic acc_req = 1'b0, seq_busy = 1'b0;
   logic seq_ras_n = 1'b1, seq_cas_n = 1'b1, seq_we_n = 1'b1;
   logic acc_gnt, init_done, dram_ras_n, dram_cas_n, dram_we_n;
   int   cyc = 0, n_chk = 0, n_fail = 0;
   bit   done = 1'b0;
   exp_t exp_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   dram_refresh_sched #(.PAUSE_CYC(P), .INTERVAL_CYC(I)) i_dram_refresh_sched (
      .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .seq_busy(seq_busy),
      .seq_ras_n(seq_ras_n), .seq_cas_n(seq_cas_n), .seq_we_n(seq_we_n),
      .acc_gnt(acc_gnt), .init_done(init_done),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n)
   );

   task automatic check(bit ok, string req, int act, int expv, string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
      end
   endtask

   task automatic expect_ref(int t, string req);
      exp_t e;
      e.t = t; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic at(int n);
      while (cyc < n) @(negedge clk);
      #1;
   endtask

   // monitor: detect refresh cycles at the pins, compare with the scoreboard
   bit prev_cas = 1'b1, in_ref = 1'b0, shape_ok = 1'b1;
   int off = 0, hi_run = 0;
   always @(negedge clk) begin : mon
      exp_t e;
      if (rst_n && !done) begin
         if (in_ref) begin
            off++;
            if (dram_cas_n != (off >= TCSR + TCHR) ||
                dram_ras_n != !(off >= TCSR && off < TCSR + TRAS) || !dram_we_n)
               shape_ok = 1'b0;
            if (off == WIN - 1) begin
               in_ref = 1'b0;
               check(shape_ok, "R3 R4 R5", int'(shape_ok), 1, "refresh strobe shape");
            end
         end else if (prev_cas && !dram_cas_n && dram_ras_n) begin
            if (exp_q.size() > 0) begin
               e = exp_q.pop_front();
               check(cyc == e.t, e.req, cyc, e.t, "refresh CAS fall cycle");
            end else
               check(1'b0, "R7", cyc, -1, "unexpected refresh");
            check(hi_run >= TCRP, "R5", hi_run, TCRP, "strobes high before refresh");
            in_ref   = 1'b1;
            off      = 0;
            shape_ok = dram_we_n;
         end
         hi_run   = (dram_ras_n && dram_cas_n) ? hi_run + 1 : 0;
         prev_cas = dram_cas_n;
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         check(1'b0, "R1", cyc, 0, "watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : drive
      // scoreboard expectations, computed from the requirements
      for (int k = 0; k < 8; k++) expect_ref(P + k * STEP + FO, "R2");
      for (int k = 1; k <= 3; k++) expect_ref(D + k * I + FO, "R6");
      expect_ref(TFULL + 7 + FO, "R8 R9");
      for (int j = 0; j < 7; j++) expect_ref(TFULL + 27 + j * STEP + FO, "R7");
      expect_ref(D + 12 * I + FO, "R6");

      #20;
      check(!init_done && !acc_gnt, "R1", {init_done, acc_gnt}, 0, "reset outputs");
      check(dram_ras_n && dram_cas_n && dram_we_n, "R1", {dram_ras_n, dram_cas_n, dram_we_n}, 7, "reset strobes");
      @(negedge clk);
      rst_n = 1'b1;

      at(5);  {seq_ras_n, seq_cas_n, seq_we_n} = 3'b000;
      at(10);
      check(dram_ras_n && dram_cas_n && dram_we_n, "R1 R10", {dram_ras_n, dram_cas_n, dram_we_n}, 7, "sequencer ignored in pause");
      check(!acc_gnt, "R1", acc_gnt, 0, "no grant in pause");
      at(20); {seq_ras_n, seq_cas_n, seq_we_n} = 3'b111;
      at(P - 1);
      check(!init_done && dram_cas_n, "R1", {init_done, dram_cas_n}, 1, "idle at end of pause");
      at(P + 50);
      check(!acc_gnt && !init_done, "R2", {acc_gnt, init_done}, 0, "no grant during warm-up");
      at(D - 1);
      check(!init_done, "R2", init_done, 0, "init_done before last refresh idles");
      at(D);
      check(init_done, "R2", init_done, 1, "init_done after warm-up");
      check(acc_gnt, "R8", acc_gnt, 1, "grant once ready");

      // pass-through of a sequencer access
      at(350); seq_ras_n = 1'b0;
      at(352); seq_cas_n = 1'b0; seq_we_n = 1'b0;
      at(353);
      check({dram_ras_n, dram_cas_n, dram_we_n} == 3'b000, "R10",
            {dram_ras_n, dram_cas_n, dram_we_n}, 0, "pins follow sequencer");
      at(356); {seq_ras_n, seq_cas_n, seq_we_n} = 3'b111;
      at(357);
      check({dram_ras_n, dram_cas_n, dram_we_n} == 3'b111, "R10",
            {dram_ras_n, dram_cas_n, dram_we_n}, 7, "pins follow sequencer release");

      // hold access requests: requests accumulate, then one refresh is forced
      at(630); acc_req = 1'b1;
      at(1500);
      check(acc_gnt, "R8", acc_gnt, 1, "grant while below limit");
      at(TFULL - 2); seq_busy = 1'b1;
      at(TFULL - 1);
      check(acc_gnt, "R8", acc_gnt, 1, "grant with seven pending");
      at(TFULL);
      check(!acc_gnt, "R8", acc_gnt, 0, "grant withheld at limit");
      at(TFULL + 5);
      check(dram_ras_n && dram_cas_n, "R9", {dram_ras_n, dram_cas_n}, 3, "no refresh while busy");
      at(TFULL + 7); seq_busy = 1'b0;
      at(TFULL + 7 + STEP);
      check(acc_gnt, "R8", acc_gnt, 1, "grant back after forced refresh");
      at(TFULL + 27); acc_req = 1'b0;

      at(D + 12 * I + 40);
      check(exp_q.size() == 0, "R7", exp_q.size(), 0, "all expected refreshes seen");
      check(init_done, "R2", init_done, 1, "init_done stays high");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule